// File: doc/BRIEF.md
# Packed Bit-Shift Unit

This block shifts a 64-bit operand split into equal lanes: four 16-bit lanes, two 32-bit lanes or a single 64-bit lane. Every lane is shifted by the same count, either left with zero fill, right with zero fill, or right with sign fill. The count comes in as a full 64-bit value. A decoder outside the block can drive it from a register or from a zero-extended 8-bit immediate.

A count that is wider than a lane does not wrap. A logical shift by such a count clears the lane. An arithmetic shift by such a count fills the lane with its original sign bit. Arithmetic shifts are defined only for 16-bit and 32-bit lanes. Any combination of lane size and shift kind that is not defined raises an error flag and returns the operand unchanged.

The unit is fully pipelined. It accepts one operation per cycle and returns each result two cycles later.

Top module: `simd_shift_unit`

## Requirements
- R1: The lane size code `lane_sel` selects the lane layout: 2'b00 gives four 16-bit lanes, 2'b01 gives two 32-bit lanes and 2'b10 gives one 64-bit lane. No bit moves across a lane boundary.
- R2: Shift kind code 2'b00 (left logical) shifts each lane left by the count and fills the vacated low-order bits with zeros.
- R3: Shift kind code 2'b01 (right logical) shifts each lane right by the count and fills the vacated high-order bits with zeros.
- R4: Shift kind code 2'b10 (right arithmetic) shifts each lane right by the count and fills the vacated high-order bits with that lane's original top bit.
- R5: For a logical shift, a count greater than or equal to the lane width (16, 32 or 64) gives an all-zero result. The whole 64-bit count is compared, so a set bit anywhere above the shift field also counts as over range.
- R6: For an arithmetic shift, a count greater than or equal to the lane width gives lanes whose every bit equals that lane's original top bit. The whole 64-bit count is compared here as well.
- R7: A count of zero returns the operand unchanged for every legal lane size and shift kind.
- R8: `res_valid` is high exactly two cycles after a cycle with `op_valid` high. An operation can be accepted every cycle.
- R9: Three combinations are illegal: an arithmetic shift with 64-bit lanes, lane code 2'b11, and kind code 2'b11. For these, `res_err` is 1 and `res_data` equals the operand. `res_err` is 0 for every legal operation and whenever `res_valid` is low.
- R10: While reset is asserted, `res_valid`, `res_err` and `res_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation accepted this cycle |
| op_data | input | 64 | Operand to shift |
| op_count | input | 64 | Shift count, full width |
| lane_sel | input | 2 | Lane size code |
| shift_kind | input | 2 | Shift kind code |
| res_valid | output | 1 | Result valid |
| res_data | output | 64 | Shifted result |
| res_err | output | 1 | Illegal lane size / kind combination |

## Verification
The decoded stage-one state sits between the operand and the lane shifters. That state is the over-range flag, the truncated shift amount and the illegal flag. If any of it is wrong, the result word is wrong two cycles after the offending operation, with no effect on neighbouring operations. An over-range flag that is wrongly set or clear shows as a zero or sign-filled lane where shifted data was due, or the reverse. The most telling case is a count that has only high bits set. A lost valid bit shows at once as a missing or extra `res_valid` pulse in the same two-cycle slot.

// File: rtl/pshift_pkg.sv
package pshift_pkg;

  typedef enum logic [1:0] {
    LANE_16  = 2'b00,
    LANE_32  = 2'b01,
    LANE_64  = 2'b10,
    LANE_RSV = 2'b11
  } lane_e;

  typedef enum logic [1:0] {
    OP_SLL = 2'b00,
    OP_SRL = 2'b01,
    OP_SRA = 2'b10,
    OP_RSV = 2'b11
  } op_e;

  function automatic logic combo_illegal(input lane_e lane, input op_e op);
    return (lane == LANE_RSV) || (op == OP_RSV) ||
           ((op == OP_SRA) && (lane == LANE_64));
  endfunction

endpackage

// File: rtl/shift_decode.sv
module shift_decode
  import pshift_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CNT_W  = 64,
  localparam int unsigned AMT_W = $clog2(DATA_W)
) (
  input  logic [CNT_W-1:0] count,
  input  lane_e            lane,
  input  op_e              op,
  output logic             sat,
  output logic [AMT_W-1:0] amt,
  output logic             bad
);

  localparam int unsigned LOG_16 = $clog2(DATA_W / 4);
  localparam int unsigned LOG_32 = $clog2(DATA_W / 2);
  localparam int unsigned LOG_64 = $clog2(DATA_W);

  // Any set bit at or above the lane's log2 width means count >= width.
  function automatic logic over_range(input logic [CNT_W-1:0] c,
                                      input int unsigned lw);
    return (c >> lw) != '0;
  endfunction

  always_comb begin
    unique case (lane)
      LANE_16: sat = over_range(count, LOG_16);
      LANE_32: sat = over_range(count, LOG_32);
      default: sat = over_range(count, LOG_64);
    endcase
  end

  assign amt = count[AMT_W-1:0];
  assign bad = combo_illegal(lane, op);

endmodule

// File: rtl/shift_lane_array.sv
module shift_lane_array
  import pshift_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 16,
  localparam int unsigned AMT_W  = $clog2(DATA_W),
  localparam int unsigned SH_W   = $clog2(LANE_W),
  localparam int unsigned LANES  = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] data,
  input  logic [AMT_W-1:0]  amt,
  input  op_e               op,
  input  logic              sat,
  output logic [DATA_W-1:0] res
);

  function automatic logic [LANE_W-1:0] lane_op(input logic [LANE_W-1:0] x,
                                                input logic [SH_W-1:0]   a,
                                                input op_e               kind,
                                                input logic              over);
    logic [LANE_W-1:0] y;
    unique case (kind)
      OP_SLL:  y = over ? '0 : (x << a);
      OP_SRL:  y = over ? '0 : (x >> a);
      OP_SRA:  y = over ? {LANE_W{x[LANE_W-1]}} : LANE_W'($signed(x) >>> a);
      default: y = x;
    endcase
    return y;
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign res[g*LANE_W +: LANE_W] =
      lane_op(data[g*LANE_W +: LANE_W], amt[SH_W-1:0], op, sat);
  end

endmodule

// File: rtl/simd_shift_unit.sv
module simd_shift_unit
  import pshift_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CNT_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [DATA_W-1:0] op_data,
  input  logic [CNT_W-1:0]  op_count,
  input  logic [1:0]        lane_sel,
  input  logic [1:0]        shift_kind,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              res_err
);

  localparam int unsigned AMT_W    = $clog2(DATA_W);
  localparam int unsigned N_SIZES  = 3;

  // Stage-one decode (combinational on the inputs)
  logic             dec_sat;
  logic [AMT_W-1:0] dec_amt;
  logic             dec_bad;

  shift_decode #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_decode (
    .count (op_count),
    .lane  (lane_e'(lane_sel)),
    .op    (op_e'(shift_kind)),
    .sat   (dec_sat),
    .amt   (dec_amt),
    .bad   (dec_bad)
  );

  // Stage-one registers
  logic              s1_valid;
  logic [DATA_W-1:0] s1_data;
  logic [AMT_W-1:0]  s1_amt;
  logic              s1_sat;
  logic              s1_bad;
  lane_e             s1_lane;
  op_e               s1_op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_data  <= '0;
      s1_amt   <= '0;
      s1_sat   <= 1'b0;
      s1_bad   <= 1'b0;
      s1_lane  <= LANE_16;
      s1_op    <= OP_SLL;
    end else begin
      s1_valid <= op_valid;
      if (op_valid) begin
        s1_data <= op_data;
        s1_amt  <= dec_amt;
        s1_sat  <= dec_sat;
        s1_bad  <= dec_bad;
        s1_lane <= lane_e'(lane_sel);
        s1_op   <= op_e'(shift_kind);
      end
    end
  end

  // One lane array per lane size
  logic [DATA_W-1:0] size_res [N_SIZES];

  for (genvar v = 0; v < N_SIZES; v++) begin : g_size
    localparam int unsigned LW = DATA_W >> (N_SIZES - 1 - v);
    shift_lane_array #(.DATA_W(DATA_W), .LANE_W(LW)) u_lanes (
      .data (s1_data),
      .amt  (s1_amt),
      .op   (s1_op),
      .sat  (s1_sat),
      .res  (size_res[v])
    );
  end

  // Named selection result, visible for checking
  logic [DATA_W-1:0] s2_next;

  always_comb begin
    if (s1_bad) begin
      s2_next = s1_data;
    end else begin
      unique case (s1_lane)
        LANE_16: s2_next = size_res[0];
        LANE_32: s2_next = size_res[1];
        default: s2_next = size_res[2];
      endcase
    end
  end

  // Stage-two (output) registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_err   <= 1'b0;
    end else begin
      res_valid <= s1_valid;
      res_err   <= s1_valid & s1_bad;
      if (s1_valid) res_data <= s2_next;
    end
  end

endmodule

// File: rtl/simd_shift_unit_chk.sv
module simd_shift_unit_chk #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CNT_W  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [DATA_W-1:0] op_data,
  input logic [CNT_W-1:0]  op_count,
  input logic [1:0]        lane_sel,
  input logic [1:0]        shift_kind,
  input logic              s1_valid,
  input logic              res_valid,
  input logic [DATA_W-1:0] res_data,
  input logic              res_err
);

  localparam int unsigned QW = DATA_W / 4;
  localparam int unsigned HW = DATA_W / 2;

  // Cycles since reset, saturating
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  logic ovr_now;
  logic legal_now;
  logic [DATA_W-1:0] fill_now;

  always_comb begin
    case (lane_sel)
      2'b00:   ovr_now = op_count >= CNT_W'(QW);
      2'b01:   ovr_now = op_count >= CNT_W'(HW);
      default: ovr_now = op_count >= CNT_W'(DATA_W);
    endcase
    legal_now = (lane_sel != 2'b11) && (shift_kind != 2'b11) &&
                !((shift_kind == 2'b10) && (lane_sel == 2'b10));
    for (int i = 0; i < DATA_W; i++) begin
      if (lane_sel == 2'b00) fill_now[i] = op_data[(i / QW) * QW + QW - 1];
      else                   fill_now[i] = op_data[(i / HW) * HW + HW - 1];
    end
  end

  assert_stage_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1) |-> (s1_valid == $past(op_valid)));

  assert_out_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (res_valid == $past(op_valid, 2)));

  assert_err_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (res_err == ($past(op_valid, 2) && !$past(legal_now, 2))));

  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !res_err);

  assert_err_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && res_valid && res_err) |-> (res_data == $past(op_data, 2)));

  assert_zero_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(op_valid, 2) && $past(legal_now, 2) &&
     ($past(op_count, 2) == '0)) |-> (res_data == $past(op_data, 2)));

  assert_logic_over_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(op_valid, 2) && $past(legal_now, 2) &&
     ($past(shift_kind, 2) != 2'b10) && $past(ovr_now, 2)) |-> (res_data == '0));

  assert_arith_over_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && $past(op_valid, 2) && $past(legal_now, 2) &&
     ($past(shift_kind, 2) == 2'b10) && $past(ovr_now, 2))
    |-> (res_data == $past(fill_now, 2)));

endmodule

bind simd_shift_unit simd_shift_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .op_data    (op_data),
  .op_count   (op_count),
  .lane_sel   (lane_sel),
  .shift_kind (shift_kind),
  .s1_valid   (s1_valid),
  .res_valid  (res_valid),
  .res_data   (res_data),
  .res_err    (res_err)
);

// File: tb/tb_simd_shift_unit.sv
`timescale 1ns/1ps
module tb_simd_shift_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [63:0] op_data = '0;
  logic [63:0] op_count = '0;
  logic [1:0]  lane_sel = '0;
  logic [1:0]  shift_kind = '0;
  logic        res_valid;
  logic [63:0] res_data;
  logic        res_err;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  simd_shift_unit dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_data(op_data),
    .op_count(op_count), .lane_sel(lane_sel), .shift_kind(shift_kind),
    .res_valid(res_valid), .res_data(res_data), .res_err(res_err)
  );

  typedef struct {
    logic        v;
    logic [63:0] d;
    logic        e;
    string       tag;
  } exp_t;

  exp_t h0, h1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference, bit by bit
  function automatic exp_t model(input logic v, input logic [63:0] d,
                                 input logic [63:0] c, input logic [1:0] ln,
                                 input logic [1:0] kd);
    exp_t r;
    int w;
    r.v = v;
    w = (ln == 2'b00) ? 16 : (ln == 2'b01) ? 32 : 64;
    r.e = v && ((ln == 2'b11) || (kd == 2'b11) || (kd == 2'b10 && ln == 2'b10));
    if (r.e || (ln == 2'b11) || (kd == 2'b11) || (kd == 2'b10 && ln == 2'b10)) begin
      r.d = d;
      r.tag = "R9";
      return r;
    end
    for (int b = 0; b < 64; b++) begin
      int base = b - (b % w);
      int p = b % w;
      logic sign = d[base + w - 1];
      logic bv;
      if (c >= 64'(w)) begin
        bv = (kd == 2'b10) ? sign : 1'b0;
      end else begin
        int s = int'(c);
        if (kd == 2'b00)      bv = (p >= s) ? d[b - s] : 1'b0;
        else if (kd == 2'b01) bv = (p + s < w) ? d[b + s] : 1'b0;
        else                  bv = (p + s < w) ? d[b + s] : sign;
      end
      r.d[b] = bv;
    end
    if (c == 0)            r.tag = "R7";
    else if (c >= 64'(w))  r.tag = (kd == 2'b10) ? "R6" : "R5";
    else if (kd == 2'b00)  r.tag = "R1/R2";
    else if (kd == 2'b01)  r.tag = "R1/R3";
    else                   r.tag = "R1/R4";
    return r;
  endfunction

  task automatic check_out();
    chk(res_valid === h1.v, "R8", "res_valid", 64'(res_valid), 64'(h1.v));
    if (h1.v) begin
      chk(res_data === h1.d, h1.tag, "res_data", res_data, h1.d);
      chk(res_err === h1.e, "R9", "res_err", 64'(res_err), 64'(h1.e));
    end else begin
      chk(res_err === 1'b0, "R9", "res_err idle", 64'(res_err), 64'd0);
    end
  endtask

  task automatic step(input logic v, input logic [63:0] d, input logic [63:0] c,
                      input logic [1:0] ln, input logic [1:0] kd);
    @(negedge clk);
    check_out();
    h1 = h0;
    h0 = model(v, d, c, ln, kd);
    op_valid = v; op_data = d; op_count = c; lane_sel = ln; shift_kind = kd;
  endtask

  localparam logic [63:0] PAT = 64'h8001_4002_F00F_1234;
  localparam logic [63:0] NEG = 64'hC350_7FFF_8765_0421;

  initial begin
    h0 = '{v: 1'b0, d: '0, e: 1'b0, tag: "R8"};
    h1 = h0;
    // R10: reset state
    repeat (3) begin
      @(negedge clk);
      chk(res_valid === 1'b0, "R10", "res_valid", 64'(res_valid), 64'd0);
      chk(res_err === 1'b0, "R10", "res_err", 64'(res_err), 64'd0);
      chk(res_data === 64'd0, "R10", "res_data", res_data, 64'd0);
    end
    rst_n = 1'b1;

    // R2, R3, R4 with R1 lane isolation
    step(1, PAT, 64'd1, 2'b00, 2'b00);
    step(1, PAT, 64'd4, 2'b01, 2'b01);
    step(1, NEG, 64'd3, 2'b00, 2'b10);
    step(1, NEG, 64'd7, 2'b01, 2'b10);
    step(1, PAT, 64'd15, 2'b00, 2'b01);
    step(1, PAT, 64'd63, 2'b10, 2'b00);
    step(1, PAT, 64'd33, 2'b10, 2'b01);
    step(1, NEG, 64'd31, 2'b01, 2'b10);
    // R5: logical over range, including high count bits only
    step(1, PAT, 64'd16, 2'b00, 2'b00);
    step(1, PAT, 64'd32, 2'b01, 2'b01);
    step(1, PAT, 64'd64, 2'b10, 2'b00);
    step(1, PAT, 64'h0000_0100_0000_0000, 2'b10, 2'b01);
    step(1, PAT, 64'h8000_0000_0000_0001, 2'b00, 2'b00);
    // R6: arithmetic over range
    step(1, NEG, 64'd16, 2'b00, 2'b10);
    step(1, NEG, 64'd32, 2'b01, 2'b10);
    step(1, NEG, 64'h1_0000_0000, 2'b01, 2'b10);
    step(1, NEG, 64'hFF, 2'b00, 2'b10);
    // R7: zero count
    for (int ln = 0; ln < 3; ln++)
      for (int kd = 0; kd < 3; kd++)
        if (!(ln == 2 && kd == 2)) step(1, NEG, 64'd0, 2'(ln), 2'(kd));
    // R9: illegal combinations
    step(1, NEG, 64'd5, 2'b10, 2'b10);
    step(0, PAT, 64'd1, 2'b00, 2'b00);
    step(1, PAT, 64'd2, 2'b11, 2'b00);
    step(1, PAT, 64'd2, 2'b00, 2'b11);
    step(0, PAT, 64'd2, 2'b11, 2'b11);
    step(0, PAT, 64'd2, 2'b00, 2'b00);
    // R8: mixed stream with gaps
    for (int i = 0; i < 400; i++) begin
      logic [63:0] d = {$urandom, $urandom};
      logic [63:0] c;
      int sel = $urandom_range(0, 9);
      if (sel < 6)       c = 64'($urandom_range(0, 70));
      else if (sel < 8)  c = 64'd1 << $urandom_range(6, 63);
      else               c = {$urandom, $urandom};
      step(1'($urandom_range(0, 3) != 0), d, c,
           2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)));
    end
    step(0, '0, '0, 2'b00, 2'b00);
    step(0, '0, '0, 2'b00, 2'b00);
    step(0, '0, '0, 2'b00, 2'b00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL R8 watchdog actual=%h expected=%h", 64'd1, 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule